// File: doc/BRIEF.md
# Typed Load/Store Data Converter with Signed Range Trap

This block sits between a 32-bit register file and a byte-lane memory port and converts data for typed accesses. There are three access widths (8, 16 and 32 bits), and each comes in a signed form and an unsigned (ordinal) form. On a load it picks the addressed byte lane or half-word out of the memory read word. It then widens that value to 32 bits, with sign extension for signed types and zero extension for ordinal types.

On a store it copies the low bits of the register value into every lane of the write word and raises the byte enables of the addressed lanes. Signed narrow stores first check that the full 32-bit register value fits the destination width. If it does not, the block raises a trap and drops every byte enable, so memory keeps its old contents instead of receiving a truncated value. Ordinal stores truncate without any check.

All outputs are registered. A request accepted on one clock edge shows its results after that edge, for one cycle.

Top module: `lsc_convert`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after it is released with no request, `res_valid`, `mem_be`, `mem_wdata`, `ld_data` and `st_trap` are all zero.
- R2: A request with `req_valid` high at a rising clock edge shows its results after that edge. A cycle with `req_valid` low gives `res_valid` = 0 and all other outputs zero.
- R3: Load lane selection is little-endian. With size code 0 (byte), `addr[1:0]` = k selects `mem_rdata[8k+7:8k]`. With size code 1 (16-bit), `addr[1]` selects bits 15:0 (0) or 31:16 (1), and `addr[0]` is ignored. Size codes 2 and 3 both mean a 32-bit access, which ignores the address.
- R4: A signed load (`req_signed` = 1) sign-extends the selected byte or half-word to 32 bits.
- R5: An ordinal load (`req_signed` = 0) zero-extends the selected value.
- R6: Store byte enables are as follows. A byte store gives 4'b0001 shifted left by `addr[1:0]`. A 16-bit store gives 4'b0011 when `addr[1]` = 0 and 4'b1100 when `addr[1]` = 1. A 32-bit store gives 4'b1111. Loads always give 4'b0000.
- R7: Store write data repeats the register's low byte in all four lanes for a byte store, repeats the low half-word in both halves for a 16-bit store, and is the whole register value for a 32-bit store. A load gives `mem_wdata` = 0, and a store gives `ld_data` = 0.
- R8: A signed byte store traps when the register value lies outside -128..127, for example 200 or -129. On a trap, `st_trap` = 1 and `mem_be` = 4'b0000.
- R9: A signed 16-bit store traps when the register value lies outside -32768..32767. On a trap, `mem_be` = 4'b0000.
- R10: Ordinal stores never trap, and neither do signed 32-bit stores; narrow ordinal stores silently drop the upper bits. Signed byte stores in range, including -128 and 127, complete with their enables set and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | 1 = signed type, 0 = ordinal type |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 or 3 32-bit |
| req_addr | input | 2 | Low address bits selecting the lane |
| reg_val | input | 32 | Register value to store |
| mem_rdata | input | 32 | Memory read word for loads |
| res_valid | output | 1 | Result registered from an accepted request |
| mem_be | output | 4 | Byte enables for the store |
| mem_wdata | output | 32 | Lane-replicated store data |
| ld_data | output | 32 | Extended load result |
| st_trap | output | 1 | Signed store range overflow |

## Verification
The hardest case to reach is the edge of the signed range. A value one step outside the range, such as -129 or -32769, differs from an in-range value only in its upper bits, and those bits are the same ones that the write data throws away. The stimulus table therefore places stores at both legal extremes (-128, 127, -32768) and at the values just past them. The bench compares the byte enables and the trap flag, not only the write data, which is identical in both cases.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  localparam int LANE_W = 8;

  // Map the raw size code to the width actually used (code 3 acts as word).
  function automatic size_e norm_size(input logic [1:0] code);
    case (code)
      2'd0:    return SZ_BYTE;
      2'd1:    return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction
endpackage

// File: rtl/lsc_load_align.sv
module lsc_load_align
  import lsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  size_e                                   size,
  input  logic                                    sgn,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]        addr,
  input  logic [DATA_W-1:0]                       rdata,
  output logic [DATA_W-1:0]                       result
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int HALVES = LANES / 2;
  localparam int HALF_W = 2 * LANE_W;
  localparam int AW = $clog2(LANES);

  logic [LANE_W-1:0] lane_q [LANES];
  logic [HALF_W-1:0] half_q [HALVES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_q[i] = rdata[i*LANE_W +: LANE_W];
  end
  for (genvar j = 0; j < HALVES; j++) begin : g_half
    assign half_q[j] = rdata[j*HALF_W +: HALF_W];
  end

  logic [LANE_W-1:0] byte_pick;
  logic [HALF_W-1:0] half_pick;
  logic [AW-2:0]     half_idx;

  assign half_idx  = addr[AW-1:1];
  assign byte_pick = lane_q[addr];
  assign half_pick = half_q[half_idx];

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(DATA_W-LANE_W){sgn & byte_pick[LANE_W-1]}}, byte_pick};
      SZ_HALF: result = {{(DATA_W-HALF_W){sgn & half_pick[HALF_W-1]}}, half_pick};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsc_store_pack.sv
module lsc_store_pack
  import lsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                    en,
  input  size_e                                   size,
  input  logic                                    sgn,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]        addr,
  input  logic [DATA_W-1:0]                       val,
  output logic [DATA_W/LANE_W-1:0]                be,
  output logic [DATA_W-1:0]                       wdata,
  output logic                                    trap
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int HALVES = LANES / 2;
  localparam int HALF_W = 2 * LANE_W;
  localparam int AW = $clog2(LANES);

  // Value fits a signed field of width w when bits [DATA_W-1:w-1] agree.
  logic [DATA_W-LANE_W:0] upper_b;
  logic [DATA_W-HALF_W:0] upper_h;
  logic                   over_byte;
  logic                   over_half;

  assign upper_b   = val[DATA_W-1:LANE_W-1];
  assign upper_h   = val[DATA_W-1:HALF_W-1];
  assign over_byte = !((&upper_b) || !(|upper_b));
  assign over_half = !((&upper_h) || !(|upper_h));

  logic [LANES-1:0] lane_mask;
  logic [AW-1:0]    half_base;

  assign half_base = {addr[AW-1:1], 1'b0};

  always_comb begin
    case (size)
      SZ_BYTE: begin
        lane_mask = {{(LANES-1){1'b0}}, 1'b1} << addr;
        wdata     = {LANES{val[LANE_W-1:0]}};
        trap      = en && sgn && over_byte;
      end
      SZ_HALF: begin
        lane_mask = {{(LANES-2){1'b0}}, 2'b11} << half_base;
        wdata     = {HALVES{val[HALF_W-1:0]}};
        trap      = en && sgn && over_half;
      end
      default: begin
        lane_mask = '1;
        wdata     = val;
        trap      = 1'b0;
      end
    endcase
  end

  assign be = (en && !trap) ? lane_mask : '0;
endmodule

// File: rtl/lsc_convert.sv
module lsc_convert
  import lsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW = $clog2(DATA_W/LANE_W),
  parameter int BE_W = DATA_W/LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_signed,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [BE_W-1:0]   mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] ld_data,
  output logic              st_trap
);
  size_e             size_n;
  logic              do_store;
  logic              do_load;
  logic [DATA_W-1:0] load_res;
  logic [BE_W-1:0]   pack_be;
  logic [DATA_W-1:0] pack_wdata;
  logic              pack_trap;

  assign size_n   = norm_size(req_size);
  assign do_store = req_valid && req_store;
  assign do_load  = req_valid && !req_store;

  lsc_load_align #(.DATA_W(DATA_W)) u_load (
    .size   (size_n),
    .sgn    (req_signed),
    .addr   (req_addr),
    .rdata  (mem_rdata),
    .result (load_res)
  );

  lsc_store_pack #(.DATA_W(DATA_W)) u_store (
    .en    (do_store),
    .size  (size_n),
    .sgn   (req_signed),
    .addr  (req_addr),
    .val   (reg_val),
    .be    (pack_be),
    .wdata (pack_wdata),
    .trap  (pack_trap)
  );

  // Registered request attributes, kept for the checks below.
  logic  q_store;
  logic  q_signed;
  size_e q_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      mem_be    <= '0;
      mem_wdata <= '0;
      ld_data   <= '0;
      st_trap   <= 1'b0;
      q_store   <= 1'b0;
      q_signed  <= 1'b0;
      q_size    <= SZ_BYTE;
    end else begin
      res_valid <= req_valid;
      mem_be    <= pack_be;
      mem_wdata <= do_store ? pack_wdata : '0;
      ld_data   <= do_load ? load_res : '0;
      st_trap   <= pack_trap;
      q_store   <= do_store;
      q_signed  <= req_signed;
      q_size    <= size_n;
    end
  end

  // R8 / R9: a trapped store never enables a lane.
  p_trap_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_trap |-> (mem_be == '0));

  // R10: only signed narrow stores may trap.
  p_trap_signed_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_trap |-> (res_valid && q_store && q_signed && q_size != SZ_WORD));

  // R6: loads never enable a lane.
  p_load_no_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !q_store) |-> (mem_be == '0));

  // R6: lane count of a non-trapping store matches its width.
  p_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && q_store && !st_trap) |->
      ($countones(mem_be) == ((q_size == SZ_BYTE) ? 1 : (q_size == SZ_HALF) ? 2 : BE_W)));

  // R2: an idle cycle leaves every output quiet.
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (mem_be == '0 && !st_trap && ld_data == '0 && mem_wdata == '0));

  // R7: loads and stores never drive each other's data output.
  p_data_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_store ? (ld_data == '0) : (mem_wdata == '0));
endmodule

// File: tb/lsc_convert_test.sv
module lsc_convert_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic        req_signed = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] reg_val = '0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] ld_data;
  logic        st_trap;

  always #10 clk = ~clk;  // 50 MHz

  lsc_convert uut (
    .clk, .rst_n, .req_valid, .req_store, .req_signed, .req_size,
    .req_addr, .reg_val, .mem_rdata, .res_valid, .mem_be, .mem_wdata,
    .ld_data, .st_trap
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // {req, st, sg, size, addr, reg, mem, exp_be, exp_data, exp_trap}
  localparam int VW = 4+1+1+2+2+32+32+4+32+1;
  localparam int NV = 19;
  localparam logic [VW-1:0] VEC [NV] = '{
    // loads from 80FF_7F01 (R3, R4, R5)
    {4'd4, 1'b0,1'b1,2'd0,2'd0, 32'h0, 32'h80FF7F01, 4'h0, 32'h00000001, 1'b0},
    {4'd4, 1'b0,1'b1,2'd0,2'd2, 32'h0, 32'h80FF7F01, 4'h0, 32'hFFFFFFFF, 1'b0},
    {4'd4, 1'b0,1'b1,2'd0,2'd3, 32'h0, 32'h80FF7F01, 4'h0, 32'hFFFFFF80, 1'b0},
    {4'd5, 1'b0,1'b0,2'd0,2'd3, 32'h0, 32'h80FF7F01, 4'h0, 32'h00000080, 1'b0},
    {4'd3, 1'b0,1'b1,2'd1,2'd0, 32'h0, 32'h80FF7F01, 4'h0, 32'h00007F01, 1'b0},
    {4'd4, 1'b0,1'b1,2'd1,2'd2, 32'h0, 32'h80FF7F01, 4'h0, 32'hFFFF80FF, 1'b0},
    {4'd5, 1'b0,1'b0,2'd1,2'd3, 32'h0, 32'h80FF7F01, 4'h0, 32'h000080FF, 1'b0},
    {4'd3, 1'b0,1'b1,2'd2,2'd1, 32'h0, 32'h80FF7F01, 4'h0, 32'h80FF7F01, 1'b0},
    // stores (R6, R7, R8, R9, R10)
    {4'd10,1'b1,1'b1,2'd0,2'd1, 32'hFFFFFF80, 32'h0, 4'b0010, 32'h80808080, 1'b0},
    {4'd8, 1'b1,1'b1,2'd0,2'd0, 32'h000000C8, 32'h0, 4'b0000, 32'hC8C8C8C8, 1'b1},
    {4'd10,1'b1,1'b1,2'd0,2'd2, 32'h0000007F, 32'h0, 4'b0100, 32'h7F7F7F7F, 1'b0},
    {4'd10,1'b1,1'b0,2'd0,2'd3, 32'h00000148, 32'h0, 4'b1000, 32'h48484848, 1'b0},
    {4'd6, 1'b1,1'b1,2'd1,2'd2, 32'hFFFF8000, 32'h0, 4'b1100, 32'h80008000, 1'b0},
    {4'd9, 1'b1,1'b1,2'd1,2'd0, 32'h00008000, 32'h0, 4'b0000, 32'h80008000, 1'b1},
    {4'd9, 1'b1,1'b1,2'd1,2'd1, 32'hFFFF7FFF, 32'h0, 4'b0000, 32'h7FFF7FFF, 1'b1},
    {4'd10,1'b1,1'b0,2'd1,2'd1, 32'h12345678, 32'h0, 4'b0011, 32'h56785678, 1'b0},
    {4'd10,1'b1,1'b1,2'd2,2'd3, 32'h80000000, 32'h0, 4'b1111, 32'h80000000, 1'b0},
    {4'd7, 1'b1,1'b1,2'd3,2'd2, 32'hDEADBEEF, 32'h0, 4'b1111, 32'hDEADBEEF, 1'b0},
    {4'd8, 1'b1,1'b1,2'd0,2'd1, 32'hFFFFFF7F, 32'h0, 4'b0000, 32'h7F7F7F7F, 1'b1}
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk(!res_valid && mem_be == 0 && !st_trap && ld_data == 0 && mem_wdata == 0,
        "R1 reset outputs", {mem_be, 27'd0, res_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid && mem_be == 0 && !st_trap, "R1 idle after reset",
        {mem_be, 27'd0, res_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      logic [3:0]    rq;
      logic          st;
      logic [3:0]    ebe;
      logic [31:0]   edat;
      logic          etr;
      v = VEC[i];
      {rq, st, req_signed, req_size, req_addr, reg_val, mem_rdata, ebe, edat, etr} = v;
      req_store = st;
      req_valid = 1'b1;
      @(negedge clk);
      chk(res_valid, $sformatf("R2 vec %0d valid", i), {31'd0, res_valid}, 32'd1);
      chk(mem_be == ebe, $sformatf("R%0d vec %0d byte enables", rq, i),
          {28'd0, mem_be}, {28'd0, ebe});
      chk(st_trap == etr, $sformatf("R%0d vec %0d trap", rq, i),
          {31'd0, st_trap}, {31'd0, etr});
      if (st) begin
        chk(mem_wdata == edat, $sformatf("R%0d vec %0d write data", rq, i), mem_wdata, edat);
        chk(ld_data == 0, $sformatf("R7 vec %0d load data on store", i), ld_data, 32'h0);
      end else begin
        chk(ld_data == edat, $sformatf("R%0d vec %0d load data", rq, i), ld_data, edat);
        chk(mem_wdata == 0, $sformatf("R7 vec %0d write data on load", i), mem_wdata, 32'h0);
      end
    end

    // R2: request withdrawn, outputs drop the next cycle
    req_valid = 1'b0;
    req_store = 1'b1; req_signed = 1'b0; req_size = 2'd2; reg_val = 32'hFFFFFFFF;
    @(negedge clk);
    chk(!res_valid && mem_be == 0 && mem_wdata == 0, "R2 idle outputs",
        mem_wdata, 32'h0);

    // R6: every byte lane of a store, R8 boundary -128 on lane 3
    for (int a = 0; a < 4; a++) begin
      req_valid = 1'b1; req_store = 1'b1; req_signed = 1'b1; req_size = 2'd0;
      req_addr = 2'(a); reg_val = 32'hFFFFFF80;
      @(negedge clk);
      chk(mem_be == (4'b0001 << a) && !st_trap, $sformatf("R6 byte lane %0d", a),
          {28'd0, mem_be}, {28'd0, 4'b0001 << a});
    end

    // R1: reset in the middle of a trapping store clears everything
    req_valid = 1'b1; req_store = 1'b1; req_signed = 1'b1; req_size = 2'd1;
    req_addr = 2'd0; reg_val = 32'h00010000;
    @(negedge clk);
    chk(st_trap && mem_be == 0, "R9 large positive half trap",
        {31'd0, st_trap}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!st_trap && !res_valid && mem_wdata == 0, "R1 reset mid-run",
        {31'd0, st_trap}, 32'd0);
    rst_n = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule